// File: doc/BRIEF.md
# Downstream Audio and Control Chunk Framer

This block builds the fixed-length serial chunks that travel down the optical fibre to the remote converter box. Each chunk holds one differential sample pair for each audio channel, the true and complement bits of the left channel and then those of the right channel. It also holds one bit of a slow serial control clock and one bit of control data, which carry a low-rate serial peripheral (SPI-style) bus inside the audio stream. A chunk begins on each strobe from the phase controller's clock domain. The block then shifts the chunk out one bit per clock, most significant bit first, and raises a start marker with the first bit.

The first bit of every chunk is the left audio bit. The remote side samples this bit and echoes it back as the phase probe, so it carries varying data and never a fixed pattern. The remote reclockers use each chunk without buffering, so the framer emits a chunk on every strobe. If no fresh audio sample is offered at a strobe, the last sample is sent again and an underrun pulse is raised.

The control clock bit holds each level for a set number of chunks. The control data bit is taken from the control input only on the chunk where that clock falls. The controller behind the framer can therefore change its data freely while the clock is high.

Top module: `chunk_framer`

## Requirements
- R1: After a strobe is sampled high on a rising clock edge, the 8 bits of the chunk appear on `line_bit` in the next 8 clock cycles, one per cycle, in the order: left, left complement, right, right complement, control clock, control data, 0, 0.
- R2: The second bit of every chunk is the inverse of its first bit, and the fourth bit is the inverse of the third.
- R3: `line_start` is high for exactly the one cycle in which the first bit of a chunk is on `line_bit`.
- R4: When `dsd_valid` is high with the strobe, that chunk carries the `dsd_left` and `dsd_right` values presented with that strobe.
- R5: When `dsd_valid` is low with the strobe, the chunk repeats the previous audio bits (0 for both channels after reset), and `dsd_underrun` is high for one cycle, the same cycle as `line_start`.
- R6: The control clock bit is 0 after reset and changes level after every HOLD_CHUNKS chunks (default 16): chunks 1 to 16 after reset carry 0, chunks 17 to 32 carry 1, and chunk 33 carries 0.
- R7: The control data bit is 0 after reset. It takes the value of `ctl_mosi` only at the strobe of the last chunk at clock level 1, so that the change shows in the first chunk after the clock falls. At all other strobes `ctl_mosi` is ignored.
- R8: Once a chunk's 8 bits have been sent, `line_bit` stays 0 until the next strobe.
- R9: A strobe that arrives before the current chunk is complete drops the rest of that chunk, and the new chunk starts in the next cycle.
- R10: While reset is asserted, `line_bit`, `line_start` and `dsd_underrun` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| chunk_stb | input | 1 | Starts a new chunk |
| dsd_valid | input | 1 | A fresh audio sample is presented with the strobe |
| dsd_left | input | 1 | Left channel audio bit |
| dsd_right | input | 1 | Right channel audio bit |
| ctl_mosi | input | 1 | Control data bit from the embedded serial controller |
| line_bit | output | 1 | Serial chunk output, first bit first |
| line_start | output | 1 | High with the first bit of each chunk |
| dsd_underrun | output | 1 | One-cycle pulse when a strobe finds no fresh sample |

## Verification
The corner cases targeted are a strobe with no valid sample, a strobe in the middle of a chunk, the idle gap between widely spaced strobes, and the exact chunk counts at which the control clock turns. A design that latched fresh audio on an invalid strobe would send stale or garbage bits with no underrun pulse. One that ignored a mid-chunk strobe would keep shifting the old chunk and drift off the remote reclockers. An off-by-one in the hold counter would move the control clock edge by a chunk. Sampling the control data on any chunk other than the falling one would let the data change while the remote side latches it. A randomized run with gaps and restarts is compared on every clock against a queue-based reference model.

// File: rtl/cf_pkg.sv
package cf_pkg;

    // Chunk length is fixed by the line format.
    localparam int CHUNK_W = 8;

    // Assemble one chunk, first transmitted bit in the MSB.
    function automatic logic [CHUNK_W-1:0] pack_chunk(
        input logic left_bit,
        input logic right_bit,
        input logic ctl_clk,
        input logic ctl_dat
    );
        return {left_bit, ~left_bit, right_bit, ~right_bit, ctl_clk, ctl_dat, 2'b00};
    endfunction

endpackage

// File: rtl/cf_ctl_clock.sv
module cf_ctl_clock #(
    parameter int HOLD_CHUNKS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stb,
    input  logic mosi,
    output logic ctl_clk,
    output logic ctl_dat
);
    localparam int CNT_W = (HOLD_CHUNKS > 1) ? $clog2(HOLD_CHUNKS) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD_CHUNKS - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             sclk;
        logic             sdat;
    } ctl_st_t;

    ctl_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (stb) begin
            if (s_q.cnt == LAST) begin
                s_d.cnt  = '0;
                s_d.sclk = ~s_q.sclk;
                if (s_q.sclk) begin
                    s_d.sdat = mosi;
                end
            end else begin
                s_d.cnt = s_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign ctl_clk = s_q.sclk;
    assign ctl_dat = s_q.sdat;

    // R7
    dat_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.sdat != $past(s_q.sdat)) |-> ($past(s_q.sclk) && !s_q.sclk));

    // R6
    clk_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.sclk != $past(s_q.sclk)) |-> $past(stb));

    // R6
    hold_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(s_q.cnt) < HOLD_CHUNKS);

endmodule

// File: rtl/cf_audio_hold.sv
module cf_audio_hold (
    input  logic clk,
    input  logic rst_n,
    input  logic stb,
    input  logic vld,
    input  logic in_l,
    input  logic in_r,
    output logic cur_l,
    output logic cur_r,
    output logic underrun
);
    typedef struct packed {
        logic l;
        logic r;
        logic und;
    } aud_st_t;

    aud_st_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.und = 1'b0;
        if (stb) begin
            if (vld) begin
                s_d.l = in_l;
                s_d.r = in_r;
            end else begin
                s_d.und = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // Values carried by a chunk launched in this cycle.
    assign cur_l    = (stb && vld) ? in_l : s_q.l;
    assign cur_r    = (stb && vld) ? in_r : s_q.r;
    assign underrun = s_q.und;

    // R5
    repeat_on_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && !vld) |=> (s_q.und && $stable(s_q.l) && $stable(s_q.r)));

    // R5
    und_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.und |-> $past(stb));

endmodule

// File: rtl/cf_shifter.sv
module cf_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         stb,
    input  logic [W-1:0] word,
    output logic         ser,
    output logic         start
);
    localparam int AGE_W = $clog2(W + 1);
    localparam logic [AGE_W-1:0] AGE_MAX = AGE_W'(W);

    typedef struct packed {
        logic [W-1:0] sh;
        logic         start;
    } shf_st_t;

    shf_st_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.start = stb;
        if (stb) begin
            s_d.sh = word;
        end else begin
            s_d.sh = {s_q.sh[W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign ser   = s_q.sh[W-1];
    assign start = s_q.start;

    // Checker window: cycles since the last chunk start, saturating.
    logic [AGE_W-1:0] age_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            age_q <= AGE_MAX;
        end else if (stb) begin
            age_q <= '0;
        end else if (age_q != AGE_MAX) begin
            age_q <= age_q + AGE_W'(1);
        end
    end

    // R3
    start_follows_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stb |=> start);

    // R8
    idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == AGE_MAX) |-> !ser);

endmodule

// File: rtl/chunk_framer.sv
module chunk_framer #(
    parameter int HOLD_CHUNKS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic chunk_stb,
    input  logic dsd_valid,
    input  logic dsd_left,
    input  logic dsd_right,
    input  logic ctl_mosi,
    output logic line_bit,
    output logic line_start,
    output logic dsd_underrun
);
    import cf_pkg::*;

    logic                cur_l, cur_r;
    logic                ctl_clk, ctl_dat;
    logic [CHUNK_W-1:0]  word;

    cf_audio_hold u_audio (
        .clk      (clk),
        .rst_n    (rst_n),
        .stb      (chunk_stb),
        .vld      (dsd_valid),
        .in_l     (dsd_left),
        .in_r     (dsd_right),
        .cur_l    (cur_l),
        .cur_r    (cur_r),
        .underrun (dsd_underrun)
    );

    cf_ctl_clock #(.HOLD_CHUNKS(HOLD_CHUNKS)) u_ctl (
        .clk     (clk),
        .rst_n   (rst_n),
        .stb     (chunk_stb),
        .mosi    (ctl_mosi),
        .ctl_clk (ctl_clk),
        .ctl_dat (ctl_dat)
    );

    assign word = pack_chunk(cur_l, cur_r, ctl_clk, ctl_dat);

    cf_shifter #(.W(CHUNK_W)) u_shf (
        .clk   (clk),
        .rst_n (rst_n),
        .stb   (chunk_stb),
        .word  (word),
        .ser   (line_bit),
        .start (line_start)
    );

    // R2
    pair_inverse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (line_start && !chunk_stb) |=> (line_bit != $past(line_bit)));

    // R5
    und_with_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dsd_underrun |-> line_start);

    // R10
    always_comb begin
        if (!rst_n) begin
            reset_quiet_chk: assert (!line_bit && !line_start && !dsd_underrun);
        end
    end

endmodule

// File: tb/chunk_framer_tb.sv
module chunk_framer_tb;
    localparam int PERIOD = 10;
    localparam int HOLD   = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic stb = 1'b0, vld = 1'b0, dl = 1'b0, dr = 1'b0, mosi = 1'b0;
    logic ser, start, und;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    chunk_framer #(.HOLD_CHUNKS(HOLD)) u_dut (
        .clk(clk), .rst_n(rst_n), .chunk_stb(stb), .dsd_valid(vld),
        .dsd_left(dl), .dsd_right(dr), .ctl_mosi(mosi),
        .line_bit(ser), .line_start(start), .dsd_underrun(und)
    );

    initial forever #(PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Behavioural reference model.
    bit q[$];
    bit ml, mr, msclk, mdat;
    int mcnt;
    bit e_ser, e_start, e_und;

    always @(posedge clk) begin
        if (!rst_n) begin
            ml = 0; mr = 0; msclk = 0; mdat = 0; mcnt = 0;
            q.delete();
            e_ser = 0; e_start = 0; e_und = 0;
        end else begin
            e_start = stb;
            e_und   = stb && !vld;
            if (stb) begin
                if (vld) begin ml = dl; mr = dr; end
                q.delete();
                q.push_back(ml); q.push_back(!ml);
                q.push_back(mr); q.push_back(!mr);
                q.push_back(msclk); q.push_back(mdat);
                q.push_back(1'b0); q.push_back(1'b0);
                mcnt++;
                if (mcnt == HOLD) begin
                    mcnt = 0;
                    if (msclk) begin msclk = 0; mdat = mosi; end
                    else msclk = 1;
                end
            end
            e_ser = (q.size() > 0) ? q.pop_front() : 1'b0;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            chk(ser == e_ser, "R1 model line_bit", ser, e_ser);
            chk(start == e_start, "R3 model line_start", start, e_start);
            chk(und == e_und, "R5 model dsd_underrun", und, e_und);
        end
    end

    task automatic do_reset();
        rst_n = 1'b0; stb = 0; vld = 0;
        repeat (3) @(negedge clk);
        chk(!ser && !start && !und, "R10 reset outputs", {ser, start, und}, 0);
        rst_n = 1'b1;
    endtask

    // Called at a negedge; returns at the negedge showing the last bit.
    task automatic chunk(input bit v, input bit l, input bit r,
                         output logic [7:0] w, output bit u, output bit st);
        stb = 1; vld = v; dl = l; dr = r;
        @(negedge clk);
        stb = 0; vld = 0;
        w[7] = ser; u = und; st = start;
        for (int i = 6; i >= 0; i--) begin
            @(negedge clk);
            w[i] = ser;
        end
    endtask

    logic [7:0] w;
    bit u, st;

    initial begin
        @(negedge clk);
        do_reset();
        @(negedge clk);

        chunk(1, 1, 0, w, u, st);
        chk(w == 8'h90, "R4 valid sample captured", w, 8'h90);
        chk(w[6] == ~w[7] && w[4] == ~w[5], "R2 complement pairs", w, 8'h90);
        chk(st == 1, "R3 start with first bit", st, 1);
        chk(w[1:0] == 2'b00, "R1 reserved bits zero", w[1:0], 0);

        chunk(0, 0, 1, w, u, st);
        chk(w == 8'h90, "R5 repeat on missing sample", w, 8'h90);
        chk(u == 1, "R5 underrun pulse", u, 1);

        begin
            bit any_hi = 0;
            for (int i = 0; i < 12; i++) begin
                @(negedge clk);
                if (ser) any_hi = 1;
            end
            chk(any_hi == 0, "R8 idle after chunk", any_hi, 0);
        end

        // R9 restart mid-chunk
        stb = 1; vld = 1; dl = 1; dr = 1;
        @(negedge clk); stb = 0; vld = 0;
        chk(ser == 1, "R9 first chunk bit", ser, 1);
        @(negedge clk);
        @(negedge clk);
        stb = 1; vld = 1; dl = 0; dr = 0;
        @(negedge clk); stb = 0; vld = 0;
        chk(start == 1 && ser == 0, "R9 restarted chunk start", {start, ser}, 2'b10);
        @(negedge clk);
        chk(ser == 1, "R9 restarted chunk second bit", ser, 1);
        repeat (8) @(negedge clk);

        // R6 / R7 control clock timing after fresh reset
        do_reset();
        @(negedge clk);
        mosi = 1;
        for (int k = 1; k <= 33; k++) begin
            chunk(1, 0, 1, w, u, st);
            if (k == 1 || k == 16)
                chk(w[3] == 0, "R6 control clock low phase", w[3], 0);
            if (k == 17 || k == 32)
                chk(w[3] == 1, "R6 control clock high phase", w[3], 1);
            if (k == 32)
                chk(w[2] == 0, "R7 data ignored while clock high", w[2], 0);
            if (k == 33) begin
                chk(w[3] == 0, "R6 control clock falls", w[3], 0);
                chk(w[2] == 1, "R7 data taken on fall", w[2], 1);
            end
            if (k == 33)
                chk(w[7:4] == 4'b0110, "R4 audio field", w[7:4], 4'b0110);
        end
        mosi = 0;

        // Randomized run against the model, with gaps and restarts.
        for (int n = 0; n < 3000; n++) begin
            int p;
            p = $urandom_range(0, 15);
            stb  = (p < 3);
            vld  = $urandom_range(0, 3) != 0;
            dl   = $urandom_range(0, 1);
            dr   = $urandom_range(0, 1);
            mosi = $urandom_range(0, 1);
            @(negedge clk);
        end
        stb = 0;
        repeat (10) @(negedge clk);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(PERIOD * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule